// File: doc/BRIEF.md
# Two-Level Lookahead 64-Bit Adder

This block adds two 64-bit unsigned operands and a carry-in, producing a 64-bit sum and a carry-out, all in one combinational pass. Every bit position first forms a propagate term (the XOR of its operand bits) and a generate term (their AND). The bits are gathered into sixteen 4-bit groups, each summarising itself as one group propagate and one group generate. Above the groups sit two levels of 4-way lookahead carry units. The first level combines four groups into a supergroup, and the second combines the four supergroups. The carry into every group is computed by this tree, so a carry never walks from one group to the next.

The whole-word propagate and generate pair is brought out as well, so that a wider adder can place this block under a further lookahead level. The carry-out is the whole-word generate, or the whole-word propagate together with the carry-in.

Top module: `cla64_tree`

## Requirements
- R1: `sum_o` equals the low 64 bits of `a_i + b_i + cin_i`, taken as unsigned integers.
- R2: `cout_o` equals bit 64 of the 65-bit unsigned result of `a_i + b_i + cin_i`.
- R3: `grp_p_o` is 1 exactly when, in every one of the 64 bit positions, the two operand bits differ.
- R4: `grp_g_o` is 1 exactly when `a_i + b_i`, with no carry-in, does not fit in 64 bits.
- R5: `grp_p_o` and `grp_g_o` are never both 1.
- R6: `cout_o` equals `grp_g_o | (grp_p_o & cin_i)` for every input.
- R7: With `a_i` all ones, `b_i` zero and `cin_i` 1, the carry crosses all fifteen group boundaries: `sum_o` is zero, `cout_o` is 1 and `grp_p_o` is 1.
- R8: With `a_i` all ones, `b_i` equal to 1 and `cin_i` 1, `sum_o` is 1 and `cout_o` is 1.
- R9: With both operands and `cin_i` zero, `sum_o`, `cout_o`, `grp_p_o` and `grp_g_o` are all zero.
- R10: The block holds no state; every output reflects the inputs present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand, unsigned |
| b_i | input | 64 | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 64 | Low 64 bits of the sum |
| cout_o | output | 1 | Carry out of bit 63 |
| grp_p_o | output | 1 | Whole-word propagate, for cascading |
| grp_g_o | output | 1 | Whole-word generate, for cascading |

## Verification
Every result of this block is due in the very cycle its operands are applied, since there is no register between any input and any output. The bench changes the operands just after a rising clock edge and compares all four outputs with its behavioural 65-bit addition at the following falling edge, half a period later, when the logic has settled. Corner patterns come first: zero plus zero, an all-ones word with carry-in, alternating bit patterns, and a carry that must cross every group. These are followed by a run of random operand pairs, each checked against the reference on the same cycle.

// File: rtl/cla64_tree.sv
module cla64_tree #(
  parameter int WIDTH = 64,
  parameter int RADIX = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             grp_p_o,
  output logic             grp_g_o
);

  localparam int NGRP = WIDTH / RADIX;
  localparam int NSUP = NGRP / RADIX;

  // returns {P, G, c3, c2, c1} for four (p,g) pairs and a carry-in
  function automatic logic [4:0] lcu4(input logic [3:0] p, input logic [3:0] g, input logic ci);
    logic c1, c2, c3, pp, gg;
    c1 = g[0] | (p[0] & ci);
    c2 = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
    c3 = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & ci);
    pp = &p;
    gg = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
    return {pp, gg, c3, c2, c1};
  endfunction

  logic [WIDTH-1:0] bp, bg, bc;
  logic [NGRP-1:0]  gp, gg, gc;
  logic [NSUP-1:0]  sp, sg, sc;
  logic [4:0]       top;

  assign bp = a_i ^ b_i;
  assign bg = a_i & b_i;

  genvar j, k, s;
  generate
    for (j = 0; j < NGRP; j++) begin : g_grp
      logic [4:0] r;
      assign r = lcu4(bp[RADIX*j +: RADIX], bg[RADIX*j +: RADIX], gc[j]);
      assign gp[j] = r[4];
      assign gg[j] = r[3];
      assign bc[RADIX*j]     = gc[j];
      assign bc[RADIX*j + 1] = r[0];
      assign bc[RADIX*j + 2] = r[1];
      assign bc[RADIX*j + 3] = r[2];
    end
    for (k = 0; k < NSUP; k++) begin : g_sup
      logic [4:0] r;
      assign r = lcu4(gp[RADIX*k +: RADIX], gg[RADIX*k +: RADIX], sc[k]);
      assign sp[k] = r[4];
      assign sg[k] = r[3];
      assign gc[RADIX*k]     = sc[k];
      assign gc[RADIX*k + 1] = r[0];
      assign gc[RADIX*k + 2] = r[1];
      assign gc[RADIX*k + 3] = r[2];
    end
  endgenerate

  assign top = lcu4(sp, sg, cin_i);
  assign sc[0] = cin_i;
  generate
    for (s = 1; s < NSUP; s++) begin : g_sc
      assign sc[s] = top[s-1];
    end
  endgenerate

  assign sum_o   = bp ^ bc;
  assign grp_p_o = top[4];
  assign grp_g_o = top[3];
  assign cout_o  = top[3] | (top[4] & cin_i);

endmodule

module cla64_tree_chk #(
  parameter int WIDTH = 64,
  parameter int RADIX = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             grp_p_o,
  input logic             grp_g_o
);
  logic [WIDTH:0] full_w, nocin_w;
  assign full_w  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign nocin_w = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      assert_sum_R1: assert ({cout_o, sum_o} == full_w);
      assert_prop_R3: assert (grp_p_o == ((a_i ^ b_i) == {WIDTH{1'b1}}));
      assert_gen_R4: assert (grp_g_o == nocin_w[WIDTH]);
      assert_excl_R5: assert (!(grp_p_o && grp_g_o));
      if (grp_p_o) begin
        assert_pass_R7: assert (sum_o == {WIDTH{~cin_i}});
      end
    end
  end
endmodule

bind cla64_tree cla64_tree_chk #(.WIDTH(WIDTH), .RADIX(RADIX)) u_chk (.*);

// File: tb/cla64_tree_tb.sv
module cla64_tree_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a, b, sum;
  logic        cin, cout, gp, gg;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  cla64_tree u_dut (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .grp_p_o(gp), .grp_g_o(gg)
  );

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (a=%h b=%h cin=%b)", tag, act, exp, a, b, cin);
    end
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic c);
    logic [64:0] r;
    logic [64:0] rn;
    @(posedge clk);
    #1;
    a = x; b = y; cin = c;
    @(negedge clk);
    r  = {1'b0, x} + {1'b0, y} + {64'd0, c};
    rn = {1'b0, x} + {1'b0, y};
    chk("R1 sum", {1'b0, sum}, {1'b0, r[63:0]});
    chk("R2 cout", {64'd0, cout}, {64'd0, r[64]});
    chk("R3 grp_p", {64'd0, gp}, {64'd0, ((x ^ y) == '1)});
    chk("R4 grp_g", {64'd0, gg}, {64'd0, rn[64]});
    chk("R5 excl", {64'd0, gp & gg}, 65'd0);
    chk("R6 cascade", {64'd0, cout}, {64'd0, gg | (gp & c)});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 / R10: zero inputs held during reset give zero outputs
    chk("R9 zero sum", {cout, sum}, 65'd0);
    chk("R9 zero pg", {63'd0, gp, gg}, 65'd0);
    rst_n = 1'b1;

    apply('0, '0, 1'b0);
    chk("R9 zero after", {cout, sum}, 65'd0);

    apply('1, 64'd0, 1'b1);
    chk("R7 chain sum", {1'b0, sum}, 65'd0);
    chk("R7 chain cout", {64'd0, cout}, 65'd1);
    chk("R7 chain p", {64'd0, gp}, 65'd1);

    apply('1, 64'd1, 1'b1);
    chk("R8 ones sum", {1'b0, sum}, 65'd1);
    chk("R8 ones cout", {64'd0, cout}, 65'd1);

    apply({32{2'b10}}, {32{2'b01}}, 1'b0);
    apply({32{2'b10}}, {32{2'b01}}, 1'b1);
    apply({32{2'b10}}, {32{2'b10}}, 1'b1);
    apply({16{4'hF, 4'h0}}, {16{4'h0, 4'hF}}, 1'b1);
    apply(64'h0000_0000_0000_000F, 64'h0000_0000_0000_0001, 1'b0);
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    apply(64'h0FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0);

    for (int i = 0; i < 400; i++) begin
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end
    for (int i = 0; i < 64; i++) begin
      // R10: a single carry-producing bit at each position, result same cycle
      apply(64'd1 << i, ~(64'd0) << i, 1'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule